// File: doc/BRIEF.md
# Watchdog Timer with Posted Register Writes

This block is a watchdog for a slow 32 kHz time base. Each slow tick reaches it as a one-cycle strobe, `tick_i`, on the fast bus clock. Software sees a small 32-bit register bank through single-cycle reads and writes. An up-counter advances on the slow ticks, either directly or through a power-of-two prescaler. When the counter overflows while the watchdog is armed, the block raises a one-cycle reset request and restarts the count from the load value.

Every write to a writable register is posted. The bus accepts the write at once and sets a pending bit for that register. The write takes effect on the counter side a fixed number of slow ticks later, and the pending bit clears at that moment.

Arming needs two start words written one after the other. Disarming needs two stop words written one after the other. Software keeps an armed watchdog from firing by writing the trigger register with a value that differs from the one it holds; writing the same value again does nothing.

Top module: `wdog_posted`

## Requirements
- R1: After reset every read returns 0. Word addresses: 0 control, 1 load, 2 counter (read-only), 3 trigger, 4 arm (reads bit 0 = armed), 5 pending status. Addresses 6 and 7 always read 0.
- R2: A write that is accepted sets its pending bit: control bit 0, load bit 1, trigger bit 2, arm bit 3. A write is not counted on a tick that falls in its own accept cycle. It takes effect on the 4th slow tick after acceptance, and its bit clears on that same tick. Until then the register reads its old value.
- R3: A write to a register whose pending bit is set is dropped.
- R4: The block arms only when an applied 0x4444 directly follows an applied 0xBBBB on the arm register.
- R5: The block disarms only when an applied 0x5555 directly follows an applied 0xAAAA on the arm register.
- R6: Any other applied arm-register word between the two words of a pair cancels the sequence. A second word without its first word has no effect.
- R7: While disarmed the counter holds its value. While armed with the prescaler off, it increments once per tick. An arm or control change that applies on a tick takes effect from the next tick.
- R8: Control bit 0 enables the prescaler and bits 3:1 hold a ratio r. With the prescaler enabled, the counter advances once every 2^r ticks, counted from the moment of arming.
- R9: An applied trigger write whose value differs from the held trigger value reloads the counter from the held load value. This reload takes priority over counting. An applied trigger write equal to the held value has no effect.
- R10: When an armed counter at all-ones advances, it reloads from the load value and `rst_req_o` is high for exactly one clock, the clock after that tick.
- R11: If a trigger reload and an overflow fall on the same tick, the reload wins and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per 32 kHz tick |
| we_i | input | 1 | Write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| rst_req_o | output | 1 | Reset request pulse on overflow |

## Verification
The two functions that can fall in the same cycle are a posted trigger reload and a counter overflow. The bench waits until the counter sits three below all-ones, then posts a new trigger value. The fourth tick after that then both applies the reload and would have overflowed the counter. The bench judges the case by the missing reset pulse and a counter equal to the load value. A cycle-level reference model also checks the output every clock around that tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;
  localparam int NSLOT  = 4;

  // slot order is also the pending-status bit order
  localparam int SL_CTRL = 0;
  localparam int SL_LOAD = 1;
  localparam int SL_TRIG = 2;
  localparam int SL_ARM  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARM   = 3'd4;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd5;

  localparam logic [15:0] KEY_ON1  = 16'hBBBB;
  localparam logic [15:0] KEY_ON2  = 16'h4444;
  localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [15:0] KEY_OFF2 = 16'h5555;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ON, SEQ_OFF} seq_e;

  function automatic logic [ADDR_W-1:0] slot_addr(int s);
    case (s)
      SL_CTRL: return A_CTRL;
      SL_LOAD: return A_LOAD;
      SL_TRIG: return A_TRIG;
      default: return A_ARM;
    endcase
  endfunction
endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
  parameter int DW         = 32,
  parameter int POST_TICKS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic          apply_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(POST_TICKS + 1);

  logic          pend_q;
  logic [CW-1:0] left_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      left_q <= '0;
      data_q <= '0;
    end else if (wr_i && !pend_q) begin
      pend_q <= 1'b1;
      left_q <= CW'(POST_TICKS);
      data_q <= wdata_i;
    end else if (pend_q && tick_i) begin
      left_q <= left_q - 1'b1;
      if (left_q == CW'(1)) pend_q <= 1'b0;
    end
  end

  assign apply_o = pend_q && tick_i && (left_q == CW'(1));
  assign pend_o  = pend_q;
  assign data_o  = data_q;

  assert_pend_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tick_i) |=> pend_q);
  assert_pend_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(tick_i));
  assert_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && wr_i) |=> $stable(data_q));
endmodule

// File: rtl/wdt_arm_seq.sv
module wdt_arm_seq
  import wdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          apply_i,
  input  logic [DW-1:0] data_i,
  output logic          run_o
);
  seq_e st_q;
  logic run_q;
  logic is_on1, is_on2, is_off1, is_off2;

  assign is_on1  = data_i == DW'(KEY_ON1);
  assign is_on2  = data_i == DW'(KEY_ON2);
  assign is_off1 = data_i == DW'(KEY_OFF1);
  assign is_off2 = data_i == DW'(KEY_OFF2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      run_q <= 1'b0;
    end else if (apply_i) begin
      if (st_q == SEQ_ON && is_on2) begin
        run_q <= 1'b1;
        st_q  <= SEQ_IDLE;
      end else if (st_q == SEQ_OFF && is_off2) begin
        run_q <= 1'b0;
        st_q  <= SEQ_IDLE;
      end else if (is_on1) begin
        st_q <= SEQ_ON;
      end else if (is_off1) begin
        st_q <= SEQ_OFF;
      end else begin
        st_q <= SEQ_IDLE;
      end
    end
  end

  assign run_o = run_q;

  assert_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(apply_i && is_on2));
  assert_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(apply_i && is_off2));
  assert_cancel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && !is_on1 && !is_on2 && !is_off1 && !is_off2) |=> $stable(run_q));
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int          DW      = 32,
  parameter int          RATIO_W = 3,
  parameter logic [DW-1:0] CNT_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               pre_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [DW-1:0]      load_i,
  input  logic               reload_i,
  output logic [DW-1:0]      cnt_o,
  output logic               ovf_o
);
  localparam int PRE_W = (1 << RATIO_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [DW-1:0]    cnt_q;
  logic             pre_hit, step, at_top;

  assign pre_mask = {PRE_W{1'b1}} >> (PRE_W - int'(ratio_i));
  assign pre_hit  = pre_q >= pre_mask;
  assign step     = tick_i && run_i && (!pre_en_i || pre_hit);
  assign at_top   = &cnt_q;
  assign ovf_o    = step && at_top && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (!run_i || !pre_en_i) begin
      pre_q <= '0;
    end else if (tick_i) begin
      pre_q <= pre_hit ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_RST;
    end else if (reload_i) begin
      cnt_q <= load_i;
    end else if (step) begin
      cnt_q <= at_top ? load_i : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(cnt_q));
  assert_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == $past(load_i));
  assert_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_posted.sv
module wdog_posted
  import wdt_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              RATIO_W    = 3,
  parameter int              POST_TICKS = 4,
  parameter logic [DATA_W-1:0] LOAD_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  localparam int CTRL_W = RATIO_W + 1;

  logic [NSLOT-1:0]  pend_v, apply_v;
  logic [DATA_W-1:0] sdata [1:NSLOT-1];
  logic [CTRL_W-1:0] ctrl_sd;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic wr;
    assign wr = we_i && (addr_i == slot_addr(s));
    if (s == SL_CTRL) begin : g_narrow
      wdt_post #(.DW(CTRL_W), .POST_TICKS(POST_TICKS)) u_post (
        .clk_i, .rst_ni, .tick_i,
        .wr_i    (wr),
        .wdata_i (wdata_i[CTRL_W-1:0]),
        .pend_o  (pend_v[s]),
        .apply_o (apply_v[s]),
        .data_o  (ctrl_sd)
      );
    end else begin : g_wide
      wdt_post #(.DW(DATA_W), .POST_TICKS(POST_TICKS)) u_post (
        .clk_i, .rst_ni, .tick_i,
        .wr_i    (wr),
        .wdata_i (wdata_i),
        .pend_o  (pend_v[s]),
        .apply_o (apply_v[s]),
        .data_o  (sdata[s])
      );
    end
  end

  logic               pre_en_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [DATA_W-1:0]  load_q, trig_q, cnt;
  logic               run, ovf, trig_reload, rst_req_q;

  assign trig_reload = apply_v[SL_TRIG] && (sdata[SL_TRIG] != trig_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_en_q  <= 1'b0;
      ratio_q   <= '0;
      load_q    <= LOAD_RST;
      trig_q    <= '0;
      rst_req_q <= 1'b0;
    end else begin
      if (apply_v[SL_CTRL]) begin
        pre_en_q <= ctrl_sd[0];
        ratio_q  <= ctrl_sd[CTRL_W-1:1];
      end
      if (apply_v[SL_LOAD]) load_q <= sdata[SL_LOAD];
      if (apply_v[SL_TRIG]) trig_q <= sdata[SL_TRIG];
      rst_req_q <= ovf;
    end
  end

  wdt_arm_seq #(.DW(DATA_W)) u_arm (
    .clk_i, .rst_ni,
    .apply_i (apply_v[SL_ARM]),
    .data_i  (sdata[SL_ARM]),
    .run_o   (run)
  );

  wdt_count #(.DW(DATA_W), .RATIO_W(RATIO_W), .CNT_RST(LOAD_RST)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .run_i    (run),
    .pre_en_i (pre_en_q),
    .ratio_i  (ratio_q),
    .load_i   (load_q),
    .reload_i (trig_reload),
    .cnt_o    (cnt),
    .ovf_o    (ovf)
  );

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = DATA_W'({ratio_q, pre_en_q});
      A_LOAD:  rdata_o = load_q;
      A_COUNT: rdata_o = cnt;
      A_TRIG:  rdata_o = trig_q;
      A_ARM:   rdata_o = DATA_W'(run);
      A_PEND:  rdata_o = DATA_W'(pend_v);
      default: rdata_o = '0;
    endcase
  end

  assign rst_req_o = rst_req_q;

  assert_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  assert_armed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(run && tick_i));
  assert_collide_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_reload |=> !rst_req_o);
endmodule

// File: tb/sim_wdog_posted.sv
module sim_wdog_posted;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int pulses = 0;

  always #10 clk = ~clk;

  wdog_posted u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req)
  );

  // reference model
  int          m_slot_a [4] = '{0, 1, 3, 4};
  bit          m_pend [4];
  int          m_left [4];
  logic [31:0] m_sd [4];
  logic [31:0] m_load, m_trig, m_cnt;
  bit          m_en, m_run, m_rst;
  int          m_ratio, m_pre, m_seq;

  function automatic void m_reset();
    for (int s = 0; s < 4; s++) begin
      m_pend[s] = 0; m_left[s] = 0; m_sd[s] = '0;
    end
    m_load = '0; m_trig = '0; m_cnt = '0;
    m_en = 0; m_run = 0; m_rst = 0; m_ratio = 0; m_pre = 0; m_seq = 0;
  endfunction

  function automatic void m_step();
    bit ap [4];
    bit reload, adv, ovf;
    int mask, npre;
    for (int s = 0; s < 4; s++) begin
      ap[s] = 0;
      if (we && int'(addr) == m_slot_a[s] && !m_pend[s]) begin
        m_pend[s] = 1; m_left[s] = 4; m_sd[s] = wdata;
      end else if (m_pend[s] && tick) begin
        m_left[s]--;
        if (m_left[s] == 0) begin m_pend[s] = 0; ap[s] = 1; end
      end
    end
    reload = ap[2] && (m_sd[2] != m_trig);
    mask = (1 << m_ratio) - 1;
    adv = tick && m_run && (!m_en || m_pre >= mask);
    ovf = 0;
    if (!m_run || !m_en) npre = 0;
    else if (tick) npre = (m_pre >= mask) ? 0 : m_pre + 1;
    else npre = m_pre;
    if (reload) m_cnt = m_load;
    else if (adv) begin
      if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = m_load; ovf = 1; end
      else m_cnt = m_cnt + 1;
    end
    m_pre = npre;
    m_rst = ovf;
    if (ap[0]) begin m_en = m_sd[0][0]; m_ratio = int'(m_sd[0][3:1]); end
    if (ap[1]) m_load = m_sd[1];
    if (ap[2]) m_trig = m_sd[2];
    if (ap[3]) begin
      if (m_seq == 1 && m_sd[3] == 32'h4444) begin m_run = 1; m_seq = 0; end
      else if (m_seq == 2 && m_sd[3] == 32'h5555) begin m_run = 0; m_seq = 0; end
      else if (m_sd[3] == 32'hBBBB) m_seq = 1;
      else if (m_sd[3] == 32'hAAAA) m_seq = 2;
      else m_seq = 0;
    end
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {28'd0, 3'(m_ratio), m_en};
      3'd1: return m_load;
      3'd2: return m_cnt;
      3'd3: return m_trig;
      3'd4: return {31'd0, m_run};
      3'd5: return {28'd0, m_pend[3], m_pend[2], m_pend[1], m_pend[0]};
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (rst_req) pulses++;
      check("R10 model rst_req", {31'd0, rst_req}, {31'd0, m_rst});
      case (addr)
        3'd0: check("R8 model ctrl", rdata, m_read(addr));
        3'd2: check("R7 model count", rdata, m_read(addr));
        3'd3: check("R9 model trig", rdata, m_read(addr));
        3'd4: check("R4 model arm", rdata, m_read(addr));
        default: check("R2 model read", rdata, m_read(addr));
      endcase
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk); addr = a;
    @(posedge clk); #5;
    check(req, rdata, exp);
  endtask

  initial begin
    #3_000_000;
    total++; bad++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rst_req after reset", {31'd0, rst_req}, 32'd0);
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 3'(a), 32'd0);

    // R2 posted load
    wr(3'd1, 32'hFFFF_FFF0);
    rd_chk("R2 load pending bit", 3'd5, 32'h2);
    tk(3);
    rd_chk("R2 load not yet applied", 3'd1, 32'd0);
    tk(1);
    rd_chk("R2 pending cleared", 3'd5, 32'd0);
    rd_chk("R2 load applied", 3'd1, 32'hFFFF_FFF0);

    // R3 second write while pending dropped
    wr(3'd0, 32'h3);
    wr(3'd0, 32'h0);
    rd_chk("R3 ctrl pending", 3'd5, 32'h1);
    tk(4);
    rd_chk("R3 first ctrl kept", 3'd0, 32'h3);

    // R9 reload from trigger, R7 hold while disarmed
    wr(3'd3, 32'h1234);
    tk(4);
    rd_chk("R9 trigger reload", 3'd2, 32'hFFFF_FFF0);
    tk(5);
    rd_chk("R7 hold when disarmed", 3'd2, 32'hFFFF_FFF0);

    // R4 arm
    wr(3'd4, 32'hBBBB);
    tk(4);
    rd_chk("R4 first word alone", 3'd4, 32'd0);
    wr(3'd4, 32'h4444);
    tk(4);
    rd_chk("R4 armed", 3'd4, 32'd1);
    rd_chk("R7 arm tick no advance", 3'd2, 32'hFFFF_FFF0);

    // R8 prescaler ratio 1 -> every 2 ticks
    tk(4);
    rd_chk("R8 divided count", 3'd2, 32'hFFFF_FFF2);
    wr(3'd0, 32'h0);
    tk(4);
    rd_chk("R8 ctrl change next tick", 3'd2, 32'hFFFF_FFF4);
    tk(3);
    rd_chk("R7 per-tick count", 3'd2, 32'hFFFF_FFF7);

    // R9 same value ignored, new value reloads
    wr(3'd3, 32'h1234);
    tk(4);
    rd_chk("R9 same trigger ignored", 3'd2, 32'hFFFF_FFFB);
    wr(3'd3, 32'hFFFF_EDCB);
    tk(4);
    rd_chk("R9 new trigger reload", 3'd2, 32'hFFFF_FFF0);

    // R10 overflow
    tk(15);
    rd_chk("R10 at top", 3'd2, 32'hFFFF_FFFF);
    check("R10 no pulse yet", 32'(pulses), 32'd0);
    tk(1);
    rd_chk("R10 reload on overflow", 3'd2, 32'hFFFF_FFF0);
    check("R10 single pulse", 32'(pulses), 32'd1);

    // R11 trigger reload on the overflow tick
    tk(12);
    rd_chk("R11 three below top", 3'd2, 32'hFFFF_FFFC);
    wr(3'd3, 32'h1234);
    tk(4);
    rd_chk("R11 reload wins", 3'd2, 32'hFFFF_FFF0);
    check("R11 no reset request", 32'(pulses), 32'd1);

    // move counter away from top
    wr(3'd1, 32'h100);
    tk(4);
    wr(3'd3, 32'hFFFF_EDCB);
    tk(4);
    rd_chk("R9 reload new load", 3'd2, 32'h100);

    // R6 cancelled stop
    wr(3'd4, 32'hAAAA);
    tk(4);
    wr(3'd4, 32'h1111);
    tk(4);
    wr(3'd4, 32'h5555);
    tk(4);
    rd_chk("R6 cancelled stop", 3'd4, 32'd1);
    rd_chk("R6 still counting", 3'd2, 32'h10C);

    // R5 stop
    wr(3'd4, 32'hAAAA);
    tk(4);
    wr(3'd4, 32'h5555);
    tk(4);
    rd_chk("R5 disarmed", 3'd4, 32'd0);
    tk(3);
    rd_chk("R5 count frozen", 3'd2, 32'h114);

    // R6 second start word alone
    wr(3'd4, 32'h4444);
    tk(4);
    rd_chk("R6 lone second word", 3'd4, 32'd0);
    check("R10 total pulses", 32'(pulses), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule